// File: doc/BRIEF.md
# Prioritized Three-Source Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from three sources: an active-low external pin, an overflow pulse from a sampling-rate counter and an overflow pulse from a timer/event counter. Each request is caught in a sticky flag. A flag takes part in arbitration only while its own enable bit and a global master enable are both set. Among the sources taking part, a fixed priority picks one. The block then offers it to the core as a request line together with that source's vector address.

A two-state machine drives the offer. In `ST_IDLE` nothing is offered. On the transition idle-to-offer, taken when any enabled flag is pending, the block latches the winning source and moves to `ST_OFFER`, where the request line is high. There are three ways out of `ST_OFFER`, and each returns to `ST_IDLE`. The acknowledge transition is taken when the core acknowledges while the latched source is still the winner. It clears that source's flag and the master enable. The withdraw transition is taken when the latched source is no longer the winner, either because another source now outranks it or because nothing is pending. The block stays in `ST_OFFER` while the latched source remains the winner and no acknowledge arrives.

The core reads and writes the flags and enables through a single 8-bit control register located at data address 0x0B.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, `irq_req` is 0 and `irq_vec` is 0x00.
- R2: The control register layout is: bit 0 master enable; bits 1, 2, 3 enables for the external, sampling and timer sources; bits 4, 5, 6 flags for the external, sampling and timer sources; bit 7 reads 0. A write takes effect at address 0x0B only. `reg_rdata` shows the register when `reg_addr` is 0x0B and shows 0x00 at any other address.
- R3: A one-cycle high on `smp_ovf` or `tmr_ovf` sets the matching flag at that clock edge. A falling edge on `ext_irq_n` sets the external flag at the third rising clock edge after the fall. A rising edge on `ext_irq_n` sets nothing.
- R4: A set flag stays set until its source is acknowledged or a register write clears it.
- R5: `irq_req` is high only in `ST_OFFER`. `ST_OFFER` is entered on the clock edge after some source has its flag, its enable and the master enable all set.
- R6: When several sources are pending, the external source wins over the sampling source, and the sampling source wins over the timer source.
- R7: While `irq_req` is high, `irq_vec` is 0x04 for the external source, 0x08 for the sampling source and 0x0C for the timer source. While `irq_req` is low, `irq_vec` is 0x00.
- R8: An acknowledge (`irq_ack` high while offering, with the offered source still the winner) clears that source's flag and the master enable at the same edge. The other flags are left unchanged.
- R9: A hardware request that lands in the same cycle as a register write clearing its flag leaves the flag set.
- R10: If a different source becomes the winner, or nothing remains pending, the offer is withdrawn (`irq_req` goes low for at least one cycle) before a new source is offered. `irq_ack` outside `ST_OFFER` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_n | input | 1 | External interrupt pin, asynchronous, falling edge requests |
| smp_ovf | input | 1 | Sampling-rate counter overflow pulse |
| tmr_ovf | input | 1 | Timer/event counter overflow pulse |
| reg_addr | input | 8 | Data address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | 8 | Vector address of the offered source |
| irq_ack | input | 1 | Core accepts the offered interrupt |

## Verification
The hardest situation to reach from the ports is the withdraw transition. It needs an offer already standing for a low-priority source when a higher-priority request arrives, so that the request line must drop for one cycle and then return with a different vector. A directed sequence sets this up on purpose: the timer source is enabled and raised first, and the sampling source is pulsed while the timer offer is held unacknowledged. Random stimulus then mixes overflow pulses, external pin toggles, writes and acknowledges, including collisions of writes with hardware requests. Every cycle is compared against a bench model of the register and the offer state.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_SRC  = 3;
    localparam int GIE_BIT  = 0;
    localparam int EN_LSB   = 1;
    localparam int FLAG_LSB = 4;

    // Lower code = higher priority
    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_SMP  = 2'd1,
        SRC_TMR  = 2'd2,
        SRC_NONE = 2'd3
    } irq_src_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_st_e;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Idle level is high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_prio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic               ack_clr,
    input  irq_src_e           ack_src,
    output logic               gie,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] flag,
    output logic [DATA_W-1:0]  rdata
);

    logic               gie_d;
    logic [NUM_SRC-1:0] en_d;
    logic [NUM_SRC-1:0] flag_d;

    // Order: software write, then acknowledge clear, then hardware set
    always_comb begin
        gie_d  = gie;
        en_d   = en;
        flag_d = flag;
        if (wr_hit) begin
            gie_d  = wdata[GIE_BIT];
            en_d   = wdata[EN_LSB +: NUM_SRC];
            flag_d = wdata[FLAG_LSB +: NUM_SRC];
        end
        if (ack_clr) begin
            gie_d = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (irq_src_e'(2'(i)) == ack_src) flag_d[i] = 1'b0;
            end
        end
        flag_d = flag_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie  <= 1'b0;
            en   <= '0;
            flag <= '0;
        end else begin
            gie  <= gie_d;
            en   <= en_d;
            flag <= flag_d;
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_rd
        if (b == GIE_BIT) begin : g_gie
            assign rdata[b] = gie;
        end else if (b >= EN_LSB && b < EN_LSB + NUM_SRC) begin : g_en
            assign rdata[b] = en[b-EN_LSB];
        end else if (b >= FLAG_LSB && b < FLAG_LSB + NUM_SRC) begin : g_flag
            assign rdata[b] = flag[b-FLAG_LSB];
        end else begin : g_zero
            assign rdata[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output irq_src_e           winner,
    output logic               any
);

    always_comb begin
        winner = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) winner = irq_src_e'(2'(i));
        end
    end

    assign any = |pend;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter int          VEC_W       = 8,
    parameter logic [7:0]  CTRL_ADDR   = 8'h0B,
    parameter int          VEC_BASE    = 4,
    parameter int          VEC_STEP    = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq_n,
    input  logic              smp_ovf,
    input  logic              tmr_ovf,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CTRL_ADDR);

    logic               ext_fall;
    logic               addr_hit;
    logic               wr_hit;
    logic [NUM_SRC-1:0] hw_set;
    logic               gie_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] flag_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [DATA_W-1:0]  ctrl_rd;
    irq_src_e           win_w;
    logic               any_w;
    logic               ack_take;

    offer_st_e state_q, state_d;
    irq_src_e  src_q, src_d;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_irq_n),
        .fall  (ext_fall)
    );

    assign addr_hit = (reg_addr == SEL_ADDR);
    assign wr_hit   = reg_wr & addr_hit;
    assign hw_set   = {tmr_ovf, smp_ovf, ext_fall};

    irq_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (reg_wdata),
        .hw_set  (hw_set),
        .ack_clr (ack_take),
        .ack_src (src_q),
        .gie     (gie_w),
        .en      (en_w),
        .flag    (flag_w),
        .rdata   (ctrl_rd)
    );

    assign pend_w    = flag_w & en_w & {NUM_SRC{gie_w}};
    assign reg_rdata = addr_hit ? ctrl_rd : '0;

    irq_arbiter u_arb (
        .pend   (pend_w),
        .winner (win_w),
        .any    (any_w)
    );

    assign ack_take = (state_q == ST_OFFER) && any_w && (win_w == src_q) && irq_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_w) begin
                    state_d = ST_OFFER;
                    src_d   = win_w;
                end
            end
            ST_OFFER: begin
                if (!any_w || (win_w != src_q)) begin
                    state_d = ST_IDLE;
                end else if (irq_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        unique case (state_q)
            ST_IDLE: begin
                irq_req = 1'b0;
                irq_vec = '0;
            end
            ST_OFFER: begin
                irq_req = 1'b1;
                irq_vec = VEC_W'(VEC_BASE + VEC_STEP * int'(src_q));
            end
            default: begin
                irq_req = 1'b0;
                irq_vec = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter logic [7:0] CTRL_ADDR = 8'h0B,
    parameter int         VEC_BASE  = 4,
    parameter int         VEC_STEP  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic       smp_ovf,
    input logic       tmr_ovf,
    input logic       irq_req,
    input logic       irq_ack,
    input logic [7:0] irq_vec,
    input logic       gie,
    input logic [2:0] flags,
    input logic [2:0] pending
);

    localparam logic [7:0] V_EXT = 8'(VEC_BASE);
    localparam logic [7:0] V_SMP = 8'(VEC_BASE + VEC_STEP);
    localparam logic [7:0] V_TMR = 8'(VEC_BASE + 2 * VEC_STEP);

    logic wr_hit;
    assign wr_hit = reg_wr && (reg_addr == CTRL_ADDR);

    // R5
    req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(pending != 3'b000));

    // R7
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == V_EXT || irq_vec == V_SMP || irq_vec == V_TMR));

    // R7
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == 8'h00));

    // R6
    tmr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vec == V_TMR) |-> $past(pending[1:0] == 2'b00));

    // R8
    gie_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gie) && !$past(wr_hit)) |-> $past(irq_req && irq_ack));

    // R4
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(wr_hit || (irq_req && irq_ack)));

    // R4
    smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(wr_hit || (irq_req && irq_ack)));

    // R4
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[2]) |-> $past(wr_hit || (irq_req && irq_ack)));

    // R9
    smp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ovf |=> flags[1]);

    // R9
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flags[2]);

endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .CTRL_ADDR (CTRL_ADDR),
    .VEC_BASE  (VEC_BASE),
    .VEC_STEP  (VEC_STEP)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .smp_ovf  (smp_ovf),
    .tmr_ovf  (tmr_ovf),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .irq_vec  (irq_vec),
    .gie      (gie_w),
    .flags    (flag_w),
    .pending  (pend_w)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_irq_n = 1'b1;
    logic       smp_ovf = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic [7:0] reg_addr = 8'h0B;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_irq_n (ext_irq_n),
        .smp_ovf   (smp_ovf),
        .tmr_ovf   (tmr_ovf),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_ack   (irq_ack)
    );

    // Requirement model
    logic       m_gie;
    logic [2:0] m_en, m_flag;
    logic       m_offer;
    int         m_src;
    logic       m_s1, m_s2, m_prev;

    function automatic int winner_of(input logic [2:0] p);
        if (p[0]) return 0;
        if (p[1]) return 1;
        if (p[2]) return 2;
        return 3;
    endfunction

    function automatic logic [7:0] vec_of(input int s);
        return 8'(4 + 4 * s);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        if (a != 8'h0B) return 8'h00;
        return {1'b0, m_flag, m_en, m_gie};
    endfunction

    always @(posedge clk) begin
        logic [2:0] pend;
        logic       fall, take;
        int         win;
        if (!rst_n) begin
            m_gie = 0; m_en = 0; m_flag = 0; m_offer = 0; m_src = 3;
            m_s1 = 1; m_s2 = 1; m_prev = 1;
        end else begin
            pend = m_flag & m_en & {3{m_gie}};
            win  = winner_of(pend);
            fall = m_prev & ~m_s2;
            take = m_offer && (pend != 0) && (win == m_src) && irq_ack;
            if (reg_wr && reg_addr == 8'h0B) begin
                m_gie  = reg_wdata[0];
                m_en   = reg_wdata[3:1];
                m_flag = reg_wdata[6:4];
            end
            if (take) begin
                m_gie = 0;
                m_flag[m_src] = 1'b0;
            end
            m_flag = m_flag | {tmr_ovf, smp_ovf, fall};
            if (!m_offer) begin
                if (pend != 0) begin m_offer = 1; m_src = win; end
            end else if (pend == 0 || win != m_src || irq_ack) begin
                m_offer = 0;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_irq_n;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R2 model rdata", reg_rdata, exp_rdata(reg_addr));
        check("R5 model req", {7'b0, irq_req}, {7'b0, m_offer});
        check("R7 model vec", irq_vec, m_offer ? vec_of(m_src) : 8'h00);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 req", {7'b0, irq_req}, 8'h00);
        check("R1 vec", irq_vec, 8'h00);
        rst_n = 1'b1;
        step();

        // R2 layout and bit 7
        wr(8'hFF);
        check("R2 bit7 reads zero", reg_rdata, 8'h7F);
        step();
        check("R6 ext first", {7'b0, irq_req}, 8'h01);
        check("R7 ext vec", irq_vec, 8'h04);
        ack_once();
        check("R8 ack clears ext and gie", reg_rdata, 8'h6E);
        check("R8 req low", {7'b0, irq_req}, 8'h00);
        wr(8'h6F);
        step();
        check("R6 smp second", irq_vec, 8'h08);
        ack_once();
        check("R8 ack clears smp", reg_rdata, 8'h4E);
        wr(8'h4F);
        step();
        check("R7 tmr vec", irq_vec, 8'h0C);
        ack_once();
        check("R8 ack clears tmr", reg_rdata, 8'h0E);
        wr(8'h00);

        // R4 flag holds
        smp_ovf = 1'b1; step(); smp_ovf = 1'b0;
        check("R3 smp pulse sets flag", reg_rdata, 8'h20);
        repeat (5) step();
        check("R4 flag held", reg_rdata, 8'h20);
        check("R5 no enable no req", {7'b0, irq_req}, 8'h00);
        wr(8'h00);
        check("R4 write clears", reg_rdata, 8'h00);

        // R9 hardware set beats write clear
        tmr_ovf = 1'b1; wr(8'h00); tmr_ovf = 1'b0;
        check("R9 hw wins", reg_rdata, 8'h40);
        wr(8'h00);

        // R3 external edge latency
        ext_irq_n = 1'b0;
        step(); step();
        check("R3 ext not yet", reg_rdata, 8'h00);
        step();
        check("R3 ext third edge", reg_rdata, 8'h10);
        wr(8'h00);
        ext_irq_n = 1'b1;
        repeat (5) step();
        check("R3 rising ignored", reg_rdata, 8'h00);

        // R10 withdraw on higher-priority arrival
        wr(8'h0D);
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        step();
        check("R10 tmr offered", irq_vec, 8'h0C);
        smp_ovf = 1'b1; step(); smp_ovf = 1'b0;
        check("R10 offer still tmr", irq_vec, 8'h0C);
        step();
        check("R10 withdrawn", {7'b0, irq_req}, 8'h00);
        step();
        check("R10 smp offered", irq_vec, 8'h08);
        ack_once();
        check("R8 smp acked tmr kept", reg_rdata, 8'h4C);

        // R10 ack while idle ignored
        wr(8'h01);
        ack_once();
        check("R10 idle ack ignored", reg_rdata, 8'h01);

        // R2 other address
        reg_addr = 8'h0A; wr(8'h00);
        check("R2 other addr reads zero", reg_rdata, 8'h00);
        reg_addr = 8'h0B; step();
        check("R2 other addr write ignored", reg_rdata, 8'h01);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            smp_ovf  = ($urandom % 8) == 0;
            tmr_ovf  = ($urandom % 8) == 0;
            irq_ack  = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) ext_irq_n = ~ext_irq_n;
            reg_wr   = ($urandom % 10) == 0;
            reg_wdata = 8'($urandom);
            if (reg_wr && ($urandom % 4) == 0) reg_wdata[0] = 1'b1;
            reg_addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0B;
            step();
        end
        smp_ovf = 0; tmr_ovf = 0; irq_ack = 0; reg_wr = 0; reg_addr = 8'h0B;
        step();
        finish_run();
    end

endmodule